// File: doc/BRIEF.md
# Programmable 8-bit Down Counter with Edge-Synchronized Run Control

This block is an 8-bit reloadable down counter advanced by a slow count clock. The count clock arrives as a level already synchronous to the base clock. The block samples it on every base-clock edge and acts only on its falling edges. Software requests run or stop through a one-bit request register. The request is applied at the next falling edge of the count clock, so a stop request still lets the counter take one last step at the edge that applies it.

When the counter steps down from zero, it loads the value in the reload register and raises an underflow pulse for one base-clock cycle. Software reads the count as two 4-bit halves, low half first. The low-half read stores a copy of the high half and starts a hold window of 24 base-clock cycles. A high-half read inside that window returns the stored copy, so the two halves belong to the same count value.

Top module: `prog_down_timer`

## Requirements
- R1: After reset the count and the reload value are 0x00, and the run request, the running status and the underflow output are all 0.
- R2: A run-request write shows on `run_req_o` one base-clock cycle after the write strobe, whatever the count clock is doing.
- R3: `running_o` changes only on the base-clock edge that detects a falling edge of `tick_i` (the input sampled high, then low). At that edge it takes the current run request.
- R4: At each detected falling edge of `tick_i` where `running_o` was already 1, the count drops by one. The edge that starts the counter does not decrement it.
- R5: A stop request takes effect at the next falling edge of `tick_i`. That edge still decrements the count once, and `running_o` goes to 0.
- R6: A decrement from 0x00 loads the reload value instead, and `underflow_o` is high for exactly one base-clock cycle.
- R7: Writing the reload register changes neither the count nor any output.
- R8: While `rd_lo_i` is high, `rd_data_o` gives count bits 3:0. When neither read strobe is high, `rd_data_o` is 0.
- R9: A high-half read (`rd_hi_i`, count bits 7:4) within 24 base-clock edges of the low-half read's capture edge returns the high half stored at that capture edge. After the window it returns the live high half.
- R10: A new low-half read during the hold window stores a fresh high half and restarts the 24-edge window.
- R11: When `running_o` is 0, or no falling edge of `tick_i` is seen, the count does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Selected count clock, synchronous level |
| run_wr_i | input | 1 | Write strobe for the run request |
| run_din_i | input | 1 | Run request value (1 = run, 0 = stop) |
| reload_wr_i | input | 1 | Write strobe for the reload register |
| reload_din_i | input | 8 | Reload value |
| rd_lo_i | input | 1 | Low-half read strobe, also starts the hold window |
| rd_hi_i | input | 1 | High-half read strobe |
| rd_data_o | output | 4 | Selected half of the count |
| run_req_o | output | 1 | Read-back of the run request |
| running_o | output | 1 | Running state as applied at a count-clock falling edge |
| underflow_o | output | 1 | One-cycle pulse on reload after zero |

## Verification
- **Count-clock results:** The count, `running_o` and `underflow_o` change on the base-clock edge that first samples `tick_i` low after high. The bench samples them at the falling base-clock edge just after it, and checks `underflow_o` low again one cycle later.
- **Run request:** `run_req_o` is due one edge after its strobe. It is checked before any count-clock edge, to show that `running_o` has not yet moved.
- **Read path:** `rd_data_o` is combinational, so each read is checked one time step after the strobe is driven.
- **Hold window:** The bench counts base-clock edges from the capture edge. It reads the high half on the 24th edge and again on the 25th to pin the window boundary exactly.

// File: rtl/pdt_pkg.sv
package pdt_pkg;
  // Which half of the count the read port returns
  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_LO   = 2'd1,
    RD_HI   = 2'd2
  } rd_sel_e;
endpackage

// File: rtl/pdt_run_sync.sv
module pdt_run_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic run_req_i,
  output logic fall_o,
  output logic running_o
);
  logic tick_q;
  logic running_q, running_d;

  assign fall_o = tick_q & ~tick_i;

  always_comb begin
    running_d = running_q;
    if (fall_o) running_d = run_req_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q    <= 1'b0;
      running_q <= 1'b0;
    end else begin
      tick_q    <= tick_i;
      running_q <= running_d;
    end
  end

  assign running_o = running_q;

  assert_run_only_at_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_o |=> $stable(running_o));
  assert_run_takes_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> running_o == $past(run_req_i));
endmodule

// File: rtl/pdt_count.sv
module pdt_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall_i,
  input  logic             running_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             uf_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             uf_q, uf_d;
  logic             step;

  assign step = fall_i & running_i;

  always_comb begin
    cnt_d = cnt_q;
    uf_d  = 1'b0;
    if (step) begin
      if (cnt_q == '0) begin
        cnt_d = reload_i;
        uf_d  = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      uf_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      uf_q  <= uf_d;
    end
  end

  assign count_o = cnt_q;
  assign uf_o    = uf_q;

  assert_idle_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(fall_i && running_i) |=> $stable(count_o));
  assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_i && running_i && count_o != '0) |=> count_o == $past(count_o) - 1'b1);
  assert_reload_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
    uf_o |-> count_o == $past(reload_i));
  assert_uf_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    uf_o |=> !uf_o);
endmodule

// File: rtl/pdt_read_hold.sv
module pdt_read_hold
  import pdt_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int HOLD_CYCLES = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_lo_i,
  input  logic             rd_hi_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [CNT_W/2-1:0] rd_data_o
);
  localparam int NIB_W = CNT_W / 2;
  localparam int TW    = $clog2(HOLD_CYCLES + 1);

  logic [TW-1:0]    tmr_q, tmr_d;
  logic [NIB_W-1:0] snap_q, snap_d;
  logic             hold_act;
  rd_sel_e          sel;

  assign hold_act = (tmr_q != '0);

  always_comb begin
    tmr_d  = hold_act ? tmr_q - 1'b1 : tmr_q;
    snap_d = snap_q;
    if (rd_lo_i) begin
      tmr_d  = TW'(HOLD_CYCLES);
      snap_d = count_i[CNT_W-1:NIB_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= '0;
      snap_q <= '0;
    end else begin
      tmr_q  <= tmr_d;
      snap_q <= snap_d;
    end
  end

  always_comb begin
    if (rd_lo_i)      sel = RD_LO;
    else if (rd_hi_i) sel = RD_HI;
    else              sel = RD_NONE;
  end

  always_comb begin
    case (sel)
      RD_LO:   rd_data_o = count_i[NIB_W-1:0];
      RD_HI:   rd_data_o = hold_act ? snap_q : count_i[CNT_W-1:NIB_W];
      default: rd_data_o = '0;
    endcase
  end

  assert_window_opens_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo_i |=> hold_act);
  assert_window_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_act) |-> $past(rd_lo_i));
  assert_snap_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_lo_i |=> $stable(snap_q));
endmodule

// File: rtl/prog_down_timer.sv
module prog_down_timer #(
  parameter int CNT_W       = 8,
  parameter int HOLD_CYCLES = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             run_wr_i,
  input  logic             run_din_i,
  input  logic             reload_wr_i,
  input  logic [CNT_W-1:0] reload_din_i,
  input  logic             rd_lo_i,
  input  logic             rd_hi_i,
  output logic [CNT_W/2-1:0] rd_data_o,
  output logic             run_req_o,
  output logic             running_o,
  output logic             underflow_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  logic             run_req_q, run_req_d;
  logic [CNT_W-1:0] reload_q, reload_d;
  logic [CNT_W-1:0] count;
  logic             fall;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  always_comb begin
    run_req_d = run_wr_i    ? run_din_i    : run_req_q;
    reload_d  = reload_wr_i ? reload_din_i : reload_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      run_req_q <= 1'b0;
      reload_q  <= '0;
    end else begin
      run_req_q <= run_req_d;
      reload_q  <= reload_d;
    end
  end

  assign run_req_o = run_req_q;

  pdt_run_sync u_sync (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .tick_i    (tick_i),
    .run_req_i (run_req_q),
    .fall_o    (fall),
    .running_o (running_o)
  );

  pdt_count #(.CNT_W(CNT_W)) u_count (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .fall_i    (fall),
    .running_i (running_o),
    .reload_i  (reload_q),
    .count_o   (count),
    .uf_o      (underflow_o)
  );

  pdt_read_hold #(.CNT_W(CNT_W), .HOLD_CYCLES(HOLD_CYCLES)) u_read (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .rd_lo_i   (rd_lo_i),
    .rd_hi_i   (rd_hi_i),
    .count_i   (count),
    .rd_data_o (rd_data_o)
  );

  assert_req_readback_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    run_wr_i |=> run_req_o == $past(run_din_i));
endmodule

// File: tb/prog_down_timer_bench.sv
module prog_down_timer_bench;
  localparam int HOLD = 24;
  localparam int NV   = 6;
  // {reload value, number of count-clock edges}
  localparam logic [15:0] VEC [NV] = '{16'h0306, 16'h0004, 16'h0502,
                                       16'hFF03, 16'h0105, 16'h1207};

  logic       clk = 1'b0;
  logic       rst_n, tick, run_wr, run_din, reload_wr, rd_lo, rd_hi;
  logic [7:0] reload_din;
  logic [3:0] rd_data;
  logic       run_req, running, uf;

  int n_chk = 0, n_fail = 0, uf_seen = 0;
  logic [7:0] m_cnt, m_rel, rv;
  logic       m_run, m_req, last_uf;
  int         m_uf;

  prog_down_timer u_prog_down_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .run_wr_i(run_wr), .run_din_i(run_din),
    .reload_wr_i(reload_wr), .reload_din_i(reload_din), .rd_lo_i(rd_lo), .rd_hi_i(rd_hi),
    .rd_data_o(rd_data), .run_req_o(run_req), .running_o(running), .underflow_o(uf)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick = 0; run_wr = 0; run_din = 0; reload_wr = 0;
    reload_din = 0; rd_lo = 0; rd_hi = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_cnt = 0; m_rel = 0; m_run = 0; m_req = 0; m_uf = 0; uf_seen = 0;
  endtask

  task automatic set_run(input logic v);
    @(negedge clk) run_wr = 1; run_din = v;
    @(negedge clk) run_wr = 0;
    m_req = v;
  endtask

  task automatic set_reload(input logic [7:0] v);
    @(negedge clk) reload_wr = 1; reload_din = v;
    @(negedge clk) reload_wr = 0;
    m_rel = v;
  endtask

  // One count-clock period; sampled right after the detecting edge
  task automatic do_tick();
    @(negedge clk) tick = 1;
    @(negedge clk) tick = 0;
    @(negedge clk);
    last_uf = uf;
    if (uf) uf_seen++;
    if (m_run) begin
      if (m_cnt == 0) begin m_cnt = m_rel; m_uf++; end
      else m_cnt = m_cnt - 1;
    end
    m_run = m_req;
  endtask

  task automatic read_count(output logic [7:0] v);
    @(negedge clk) rd_lo = 1;
    #1 v[3:0] = rd_data;
    @(negedge clk) rd_lo = 0; rd_hi = 1;
    #1 v[7:4] = rd_data;
    rd_hi = 0;
  endtask

  task automatic setup_0x10();
    set_run(1);
    set_reload(8'h10);
    do_tick();
    do_tick();
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state, R8 idle read
    check("R1 run_req", run_req, 0);
    check("R1 running", running, 0);
    check("R1 underflow", uf, 0);
    check("R8 idle rd_data", rd_data, 0);
    read_count(rv);
    check("R1 count", rv, 8'h00);

    // R2 immediate read-back, R3 running waits for edge
    set_run(1);
    check("R2 run_req readback", run_req, 1);
    check("R3 running before edge", running, 0);
    do_tick();
    check("R3 running after edge", running, 1);
    read_count(rv);
    check("R4 start edge no decrement", rv, 8'h00);

    // R7 reload write has no effect on count
    set_reload(8'h10);
    read_count(rv);
    check("R7 count unchanged", rv, 8'h00);
    check("R7 underflow quiet", uf, 0);

    // R6 underflow reload and pulse width
    do_tick();
    check("R6 underflow high", last_uf, 1);
    @(negedge clk);
    check("R6 underflow one cycle", uf, 0);
    read_count(rv);
    check("R6 reload value", rv, 8'h10);

    // R9 hold window boundary (count 0x10)
    @(negedge clk) rd_lo = 1;
    #1 check("R8 low half", rd_data, 4'h0);
    @(negedge clk) rd_lo = 0;
    @(negedge clk) tick = 1;
    @(negedge clk) tick = 0;
    @(negedge clk);
    repeat (HOLD - 4) @(negedge clk);
    rd_hi = 1;
    #1 check("R9 snapshot at last edge of window", rd_data, 4'h1);
    rd_hi = 0;
    @(negedge clk) rd_hi = 1;
    #1 check("R9 live after window", rd_data, 4'h0);
    rd_hi = 0;

    // R5 stop with one last decrement (count 0x0F)
    set_run(0);
    check("R5 running before stop edge", running, 1);
    do_tick();
    check("R5 running after stop edge", running, 0);
    read_count(rv);
    check("R5 last decrement", rv, 8'h0E);
    do_tick();
    read_count(rv);
    check("R11 stopped holds", rv, 8'h0E);

    // R10 window restart
    do_reset();
    setup_0x10();
    @(negedge clk) rd_lo = 1;
    @(negedge clk) rd_lo = 0;
    repeat (17) @(negedge clk);
    rd_lo = 1;
    @(negedge clk) rd_lo = 0;
    @(negedge clk) tick = 1;
    @(negedge clk) tick = 0;
    @(negedge clk);
    repeat (8) @(negedge clk);
    rd_hi = 1;
    #1 check("R10 restarted window", rd_data, 4'h1);
    rd_hi = 0;

    // Vector table against the bench model (R4 R5 R6)
    do_reset();
    for (int i = 0; i < NV; i++) begin
      set_reload(VEC[i][15:8]);
      set_run(1);
      for (int k = 0; k < int'(VEC[i][7:0]); k++) do_tick();
      read_count(rv);
      check("R4 vector count", rv, m_cnt);
      check("R6 vector underflows", 8'(uf_seen), 8'(m_uf));
      set_run(0);
      do_tick();
      read_count(rv);
      check("R5 vector stop", rv, m_cnt);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule